// File: doc/BRIEF.md
# Source-Synchronous Double-Edge Burst Receiver

This block is the host-side receiving end of a parallel data-in burst whose 16-bit words are clocked by a strobe that the sending device drives. A burst is open only while the device request and the host acknowledge are both high. Inside that window, every change of strobe level, whether rising or falling, delivers one word. The strobe is brought into the system clock through a two-flop synchroniser. The data lines are sampled a programmable number of settle cycles after the change has been detected.

Received words go to a valid/ready stream through a small skid buffer. The host can hold the burst by dropping its ready line, either on request or automatically when the buffer is nearly full. The sender may still deliver up to two trailing words after ready falls, and the block stores them as long as they arrive inside a grace window. A strobe change that comes after the grace window is dropped and raises a sticky error flag.

The host ends a burst by raising its stop line. This is allowed only a minimum number of cycles after ready has fallen. The device ends a burst by dropping its request. All protocol times are parameters counted in system-clock cycles.

Top module: `udr_burst_rx`

## Requirements
- R1: After reset, host_rdy_o, end_o, proto_err_o and m_valid_o are all 0.
- R2: Once dev_req_i and then host_ack_i are high, host_rdy_o goes to 1. Each change of strobe_i level, whether rising or falling, adds exactly one word to the output stream, and words leave in arrival order.
- R3: Changes of strobe_i while dev_req_i or host_ack_i is low add no word to the stream.
- R4: When pause_req_i is 1, host_rdy_o goes to 0 within two cycles. Words whose strobe change is detected fewer than TRFS cycles after ready fell are still stored. Ready returns to 1 once pause_req_i is 0 again and the buffer has room.
- R5: A strobe change detected TRFS or more cycles after ready fell adds no word and sets proto_err_o to 1. The flag stays set until the next request opens a new burst, which clears it to 0.
- R6: After end_req_i is set, host_rdy_o falls first. end_o rises no sooner than TRP+1 cycles after ready fell and stays high while dev_req_i is high. end_o is 0 once dev_req_i has fallen.
- R7: If dev_req_i or host_ack_i drops during a burst, host_rdy_o falls on the next cycle. When dev_req_i drops in the same cycle as end_req_i rises, end_o never goes high. After both lines are low, a new burst can start.
- R8: While the buffer has AFREE or fewer free entries, host_rdy_o is 0. With DEPTH=8 and AFREE=2 and no reads, the sender gets ready for exactly 6 words, and 2 trailing words are kept as well, with no loss. Ready returns after draining.
- R9: While m_valid_o is 1 and m_ready_i is 0, m_valid_o stays 1 and m_data_o stays unchanged.
- R10: The stored word is the value on bus_data_i SETTLE cycles after the strobe change has been detected. A value that was still unsettled when the strobe moved is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req_i | input | 1 | Device burst request |
| host_ack_i | input | 1 | Host acknowledge from command logic |
| strobe_i | input | 1 | Device-driven data strobe, asynchronous |
| bus_data_i | input | DW | Parallel data lines |
| pause_req_i | input | 1 | Host asks to hold the burst |
| end_req_i | input | 1 | Host asks to end the burst |
| host_rdy_o | output | 1 | Host ready, 1 = sender may strobe |
| end_o | output | 1 | Host stop line, 1 = burst end requested |
| proto_err_o | output | 1 | Sticky late-strobe error |
| m_valid_o | output | 1 | Stream word valid |
| m_ready_i | input | 1 | Stream consumer ready |
| m_data_o | output | DW | Stream word |

## Verification
Two of the block's functions can meet in a single cycle: the device dropping its request and the host asking for termination. The bench provokes this by changing both lines on the same falling clock edge during an open burst. It then watches end_o for ten cycles and expects it to stay low, because loss of the request takes priority. A second overlap occurs when trailing words arrive while the buffer is nearly full and automatic holding has already dropped ready. This is judged by counting the drained words against every strobe change that was sent.

// File: rtl/udr_pkg.sv
// Shared types for the double-edge burst receiver.
package udr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,     // no request seen
        ST_ARM,      // request seen, waiting for acknowledge
        ST_RUN,      // window open, ready high
        ST_HOLD,     // ready low, trailing words tolerated
        ST_HOSTEND,  // stop line high, waiting for request to fall
        ST_DEVEND    // waiting for both lines to be released
    } udr_state_t;
endpackage

// File: rtl/udr_strobe_sync.sv
// Strobe synchroniser and capture delay.
// Brings the asynchronous strobe into clk with two flops and flags every
// change of level. An accepted change (take_i) is delayed by SETTLE cycles
// before the write pulse, so the data lines are sampled once settled.
// Assumes the strobe half-period exceeds SETTLE+3 system cycles.
module udr_strobe_sync #(
    parameter int DW     = 16,
    parameter int SETTLE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strb_i,
    input  logic [DW-1:0] data_i,
    input  logic          take_i,
    output logic          edge_o,
    output logic          wr_o,
    output logic [DW-1:0] wr_data_o
);
    logic s1, s2, lvl_q;

    // Two-flop synchroniser plus last-seen level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            lvl_q <= 1'b0;
        end else begin
            s1    <= strb_i;
            s2    <= s1;
            lvl_q <= s2;
        end
    end

    assign edge_o    = s2 ^ lvl_q;
    assign wr_data_o = data_i;

    generate
        if (SETTLE == 0) begin : g_direct
            assign wr_o = take_i;
        end else begin : g_delay
            logic [SETTLE-1:0] sh;
            // Shift accepted edges through the settle delay line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh <= '0;
                end else begin
                    sh[0] <= take_i;
                    for (int i = 1; i < SETTLE; i++) sh[i] <= sh[i-1];
                end
            end
            assign wr_o = sh[SETTLE-1];
        end
    endgenerate
endmodule

// File: rtl/udr_fifo.sv
// Skid buffer between the strobe domain logic and the output stream.
// Register-based FIFO of DEPTH words (power of two). low_room_o is set when
// AFREE or fewer entries are free. Writes to a full buffer are dropped.
module udr_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int AFREE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_i,
    output logic [DW-1:0] rd_data_o,
    output logic          valid_o,
    output logic          full_o,
    output logic          low_room_o
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LIMIT = DEPTH - AFREE;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd;

    assign valid_o    = (cnt != '0);
    assign full_o     = (cnt == (AW+1)'(DEPTH));
    assign low_room_o = (cnt >= (AW+1)'(LIMIT));
    assign do_wr      = wr_i && !full_o;
    assign do_rd      = rd_i && valid_o;
    assign rd_data_o  = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data_i;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/udr_ctrl.sv
// Burst control state machine.
// Tracks the request/acknowledge window, drives ready and stop, counts cycles
// since ready fell, accepts or rejects strobe edges and keeps the error flag.
// Loss of the window has priority over any host request.
module udr_ctrl
    import udr_pkg::*;
#(
    parameter int TRP  = 4,
    parameter int TRFS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_i,
    input  logic pause_i,
    input  logic end_req_i,
    input  logic low_room_i,
    input  logic edge_i,
    output logic take_o,
    output logic rdy_o,
    output logic end_o,
    output logic err_o
);
    localparam int MAXC = (TRP > TRFS) ? TRP : TRFS;
    localparam int CW   = $clog2(MAXC + 1);

    udr_state_t st, st_nx;
    logic [CW-1:0] cnt;
    logic win, trailing, late, want_hold, bad_edge;

    assign win       = req_i && ack_i;
    assign trailing  = (st == ST_HOLD) || (st == ST_HOSTEND);
    assign late      = (cnt >= CW'(TRFS));
    assign want_hold = pause_i || end_req_i || low_room_i;
    assign take_o    = edge_i && win && ((st == ST_RUN) || (trailing && !late));
    assign bad_edge  = edge_i && win && trailing && late;
    assign rdy_o     = (st == ST_RUN);
    assign end_o     = (st == ST_HOSTEND);

    // Next-state selection.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:    if (req_i) st_nx = ST_ARM;
            ST_ARM:     if (!req_i) st_nx = ST_IDLE;
                        else if (ack_i) st_nx = ST_RUN;
            ST_RUN:     if (!win) st_nx = ST_DEVEND;
                        else if (want_hold) st_nx = ST_HOLD;
            ST_HOLD:    if (!win) st_nx = ST_DEVEND;
                        else if (end_req_i && cnt >= CW'(TRP)) st_nx = ST_HOSTEND;
                        else if (!want_hold) st_nx = ST_RUN;
            ST_HOSTEND: if (!win) st_nx = ST_DEVEND;
            ST_DEVEND:  if (!req_i && !ack_i) st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Saturating count of cycles since ready fell.
    always_ff @(posedge clk) begin
        if (!rst_n || !trailing) cnt <= '0;
        else if (cnt < CW'(MAXC)) cnt <= cnt + 1'b1;
    end

    // Sticky late-edge flag, cleared when a new request arms the block.
    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_ARM) err_o <= 1'b0;
        else if (bad_edge)          err_o <= 1'b1;
    end
endmodule

// File: rtl/udr_burst_rx.sv
// Top of the double-edge burst receiver.
// Joins the strobe synchroniser, control FSM and skid buffer. Every accepted
// strobe level change writes one DW-bit word into the buffer; the buffer
// feeds a valid/ready stream. Times TRP, TRFS, SETTLE are in clk cycles.
module udr_burst_rx #(
    parameter int DW     = 16,
    parameter int DEPTH  = 8,
    parameter int AFREE  = 2,
    parameter int TRP    = 4,
    parameter int TRFS   = 16,
    parameter int SETTLE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_req_i,
    input  logic          host_ack_i,
    input  logic          strobe_i,
    input  logic [DW-1:0] bus_data_i,
    input  logic          pause_req_i,
    input  logic          end_req_i,
    output logic          host_rdy_o,
    output logic          end_o,
    output logic          proto_err_o,
    output logic          m_valid_o,
    input  logic          m_ready_i,
    output logic [DW-1:0] m_data_o
);
    logic          strb_edge, take, cap_wr, fifo_full, low_room;
    logic [DW-1:0] cap_data;

    udr_strobe_sync #(.DW(DW), .SETTLE(SETTLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .strb_i(strobe_i), .data_i(bus_data_i),
        .take_i(take), .edge_o(strb_edge), .wr_o(cap_wr), .wr_data_o(cap_data)
    );

    udr_ctrl #(.TRP(TRP), .TRFS(TRFS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(dev_req_i), .ack_i(host_ack_i),
        .pause_i(pause_req_i), .end_req_i(end_req_i), .low_room_i(low_room),
        .edge_i(strb_edge), .take_o(take), .rdy_o(host_rdy_o),
        .end_o(end_o), .err_o(proto_err_o)
    );

    udr_fifo #(.DW(DW), .DEPTH(DEPTH), .AFREE(AFREE)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_i(cap_wr), .wr_data_i(cap_data),
        .rd_i(m_ready_i), .rd_data_o(m_data_o), .valid_o(m_valid_o),
        .full_o(fifo_full), .low_room_o(low_room)
    );
endmodule

// File: rtl/udr_burst_rx_chk.sv
// Protocol checker for udr_burst_rx, attached by bind.
// Assumes the stimulus respects the block's timing rules.
module udr_burst_rx_chk #(
    parameter int DW  = 16,
    parameter int TRP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_i,
    input logic          ack_i,
    input logic          rdy_o,
    input logic          end_o,
    input logic          err_o,
    input logic          m_valid,
    input logic          m_ready,
    input logic [DW-1:0] m_data,
    input logic          cap_wr,
    input logic          fifo_full
);
    int since_low;

    // Cycles since ready was last seen high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || rdy_o)       since_low <= 0;
        else if (since_low < TRP + 2) since_low <= since_low + 1;
    end

    a_r2_rdy_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> $past(req_i && ack_i));

    a_r6_stop_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_o) |-> (since_low > TRP));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !cap_wr);

    a_r9_stream_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

    a_r5_err_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> !rdy_o);
endmodule

bind udr_burst_rx udr_burst_rx_chk #(.DW(DW), .TRP(TRP)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_i(dev_req_i), .ack_i(host_ack_i),
    .rdy_o(host_rdy_o), .end_o(end_o), .err_o(proto_err_o),
    .m_valid(m_valid_o), .m_ready(m_ready_i), .m_data(m_data_o),
    .cap_wr(cap_wr), .fifo_full(fifo_full)
);

// File: tb/udr_burst_rx_test.sv
module udr_burst_rx_test;
    localparam int CLK_NS = 10;
    localparam int DW = 16, DEPTH = 8, AFREE = 2, TRP = 4, TRFS = 16, SETTLE = 2;
    localparam logic [15:0] TAB [4] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h7E18};

    logic clk = 0, rst_n = 0;
    logic req = 0, ack = 0, strb = 0, pause = 0, endr = 0, mrdy = 0;
    logic [DW-1:0] data = '0;
    logic rdy, endo, err, mval;
    logic [DW-1:0] mdat;
    int total = 0, bad = 0, gcount = 0;
    logic [15:0] got [16];

    always #(CLK_NS/2) clk = ~clk;

    udr_burst_rx #(.DW(DW), .DEPTH(DEPTH), .AFREE(AFREE), .TRP(TRP),
                   .TRFS(TRFS), .SETTLE(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .dev_req_i(req), .host_ack_i(ack),
        .strobe_i(strb), .bus_data_i(data), .pause_req_i(pause),
        .end_req_i(endr), .host_rdy_o(rdy), .end_o(endo),
        .proto_err_o(err), .m_valid_o(mval), .m_ready_i(mrdy), .m_data_o(mdat)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // One strobe change; data unsettled for 3 cycles, then the real word.
    task automatic send_word(input logic [15:0] w);
        strb = ~strb;
        data = ~w;
        repeat (3) @(negedge clk);
        data = w;
        repeat (5) @(negedge clk);
    endtask

    task automatic drain();
        gcount = 0;
        while (mval) begin
            got[gcount] = mdat;
            gcount++;
            mrdy = 1;
            @(negedge clk);
            mrdy = 0;
        end
    endtask

    initial begin
        #(CLK_NS * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k, n;
        bit seen;
        logic [15:0] d0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rdy == 0, "R1", "rdy", rdy, 0);
        chk(endo == 0, "R1", "end", endo, 0);
        chk(err == 0, "R1", "err", err, 0);
        chk(mval == 0, "R1", "valid", mval, 0);

        // R3: strobes outside the window
        send_word(16'h0A0A); send_word(16'h0B0B);
        chk(mval == 0, "R3", "no word while idle", mval, 0);
        req = 1;
        repeat (2) @(negedge clk);
        send_word(16'h1111);
        chk(mval == 0, "R3", "no word without ack", mval, 0);

        // R2 / R10: table walk, double-edge capture with unsettled data
        ack = 1;
        repeat (2) @(negedge clk);
        chk(rdy == 1, "R2", "ready in window", rdy, 1);
        for (int i = 0; i < 4; i++) send_word(TAB[i]);
        drain();
        chk(gcount == 4, "R2", "word count", gcount, 4);
        for (int i = 0; i < 4; i++)
            chk(got[i] == TAB[i], "R10", "settled word", got[i], TAB[i]);

        // R9: stream holds under backpressure
        send_word(16'h2222); send_word(16'h3333);
        d0 = mdat;
        repeat (3) @(negedge clk);
        chk(mval == 1 && mdat == d0 && d0 == 16'h2222, "R9", "held word", mdat, 16'h2222);
        drain();
        chk(gcount == 2 && got[1] == 16'h3333, "R9", "order", got[1], 16'h3333);

        // R4: pause with two trailing words
        pause = 1;
        @(negedge clk); @(negedge clk);
        chk(rdy == 0, "R4", "ready low on pause", rdy, 0);
        send_word(16'h4444); send_word(16'h5555);
        // R5: late edge
        repeat (20) @(negedge clk);
        send_word(16'h6666);
        chk(err == 1, "R5", "late edge flag", err, 1);
        drain();
        chk(gcount == 2, "R5", "late word dropped", gcount, 2);
        chk(got[0] == 16'h4444 && got[1] == 16'h5555, "R4", "trailing words", got[1], 16'h5555);
        pause = 0;
        repeat (2) @(negedge clk);
        chk(rdy == 1, "R4", "ready back", rdy, 1);

        // R6: host end
        endr = 1;
        while (rdy) @(negedge clk);
        k = 0;
        while (!endo && k < 40) begin @(negedge clk); k++; end
        chk(endo == 1 && k >= TRP + 1 && k <= TRP + 3, "R6", "stop spacing", k, TRP + 1);
        chk(rdy == 0, "R6", "ready low with stop", rdy, 0);
        req = 0;
        repeat (2) @(negedge clk);
        chk(endo == 0, "R6", "stop released", endo, 0);
        ack = 0; endr = 0;
        repeat (3) @(negedge clk);

        // R5: new request clears error
        req = 1;
        repeat (2) @(negedge clk);
        chk(err == 0, "R5", "err cleared", err, 0);
        ack = 1;
        repeat (2) @(negedge clk);
        chk(rdy == 1, "R2", "ready new burst", rdy, 1);

        // R7: device end
        req = 0;
        @(negedge clk); @(negedge clk);
        chk(rdy == 0, "R7", "ready low after req drop", rdy, 0);
        ack = 0;
        repeat (2) @(negedge clk);
        req = 1; ack = 1;
        repeat (3) @(negedge clk);
        chk(rdy == 1, "R7", "restart", rdy, 1);
        // R7: end request and request drop in the same cycle
        endr = 1; req = 0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); seen |= endo; end
        chk(!seen, "R7", "no stop on coincidence", seen, 0);
        ack = 0; endr = 0;
        repeat (3) @(negedge clk);

        // R8: automatic hold near full
        req = 1; ack = 1;
        repeat (3) @(negedge clk);
        n = 0;
        while (rdy && n < 12) begin send_word(16'h8000 + 16'(n)); n++; end
        chk(n == DEPTH - AFREE, "R8", "words before hold", n, DEPTH - AFREE);
        chk(rdy == 0, "R8", "auto hold", rdy, 0);
        send_word(16'h8000 + 16'(n)); n++;
        send_word(16'h8000 + 16'(n)); n++;
        drain();
        chk(gcount == n, "R8", "no loss", gcount, n);
        for (int i = 0; i < 8; i++)
            chk(got[i] == 16'h8000 + 16'(i), "R8", "word value", got[i], 16'h8000 + i);
        repeat (3) @(negedge clk);
        chk(rdy == 1, "R8", "ready after drain", rdy, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule